// File: doc/BRIEF.md
# Page-Mode Parallel ROM Read Controller

This block lets a synchronous host read an asynchronous parallel ROM that offers a fast in-page burst and a selectable 8-bit or 16-bit data width. The host hands over a start address, a beat count and a width select through a valid/ready handshake. The controller then drives chip enable, output enable and the ROM address lines. It waits a counted number of clock cycles for each access, captures the returned data and presents each beat with a one-cycle strobe.

A page is eight 16-bit words or sixteen bytes. The first access into a page pays the full access time. Further accesses that change only the in-page bits pay the much shorter page time. In byte mode the ROM's top data pin turns into an input and carries the least significant byte address, and the controller drives it. Bursts that run past a page end are split at the boundary, and a new full-latency access starts there.

After a burst, chip enable stays low for a few idle cycles so that an immediate follow-up request to the same page and width can reuse the open page. Once that window runs out, chip enable and output enable are released and the open page is forgotten.

Top module: `prom_page_reader`

## Requirements
- R1: During and after reset, `req_ready` is 1, `rom_ce_n` and `rom_oe_n` are 1 and `rd_valid` is 0.
- R2: The first beat of a request made while chip enable is high appears `FULL_CYC+1` cycles after the accepting clock edge. `FULL_CYC` is the larger of the address access time and the output-enable time, divided by the clock period and rounded up (15 with the defaults).
- R3: A beat whose address lies in the same page, in the same width mode, as the previous access appears `PAGE_CYC+1` cycles after the previous one. `PAGE_CYC` is the page time divided by the clock period and rounded up (7 with the defaults).
- R4: When a burst crosses a page boundary, the first beat after the boundary takes `FULL_CYC+1` cycles. The page is element address bits 3 and up in word mode, and bits 4 and up in byte mode.
- R5: In word mode (`req_byte`=0), `rom_wide`=1 and `rom_lsb_drive`=0, `rom_addr` equals element address bits [ADDR_W-1:0], and `rd_data` carries all 16 ROM data bits.
- R6: In byte mode (`req_byte`=1), `rom_wide`=0 and `rom_lsb_drive`=1, `rom_lsb` is element address bit 0, `rom_addr` is element address bits [ADDR_W:1], and `rd_data` is {8'h00, ROM data[7:0]}.
- R7: A request yields `req_len+1` beats at ascending element addresses. `req_ready` is 0 until the cycle that presents the last beat.
- R8: `rom_ce_n` and `rom_oe_n` are 0 for the whole burst. They stay 0 for `IDLE_HOLD+1` idle cycles afterwards and then both return to 1.
- R9: A request accepted inside the hold window, to the open page and in the same width, takes `PAGE_CYC+1` cycles for its first beat. After a width change or after chip enable is released, the first beat takes `FULL_CYC+1` cycles.
- R10: `req_valid` and the request fields are ignored while `req_ready` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Host request strobe |
| req_ready | output | 1 | Controller can accept a request |
| req_addr | input | ADDR_W+1 | Start element address (word or byte index) |
| req_len | input | LEN_W | Number of beats minus one |
| req_byte | input | 1 | 1 selects byte mode, 0 word mode |
| rd_valid | output | 1 | One-cycle strobe for a returned beat |
| rd_data | output | DATA_W | Returned beat |
| rom_ce_n | output | 1 | ROM chip enable, active low |
| rom_oe_n | output | 1 | ROM output enable, active low |
| rom_addr | output | ADDR_W | ROM address lines |
| rom_wide | output | 1 | ROM width select, 1 for word mode |
| rom_lsb | output | 1 | Byte address LSB driven onto the dual-use top data pin |
| rom_lsb_drive | output | 1 | Output enable for the dual-use pin |
| rom_data_in | input | DATA_W | Data read back from the ROM |

## Verification
A beat is due `FULL_CYC+1` = 16 cycles after the edge that issued its address when a fresh page opens, and `PAGE_CYC+1` = 8 cycles after it when the page is reused. The bench takes a cycle stamp at the accepting edge and at every strobe, and compares each gap with the value it derives from the address sequence and page rules. ROM pins and data are sampled on the falling clock edge. Address pins are checked in the cycle right after acceptance, and the ROM model in the bench returns a computed pattern, so a beat captured from the wrong address or in the wrong width shows up as a data mismatch.

// File: rtl/prom_pkg.sv
package prom_pkg;
  typedef enum logic [0:0] {S_IDLE = 1'b0, S_WAIT = 1'b1} prom_state_e;

  function automatic int cdiv(input int num, input int den);
    return (num + den - 1) / den;
  endfunction

  function automatic int imax(input int a, input int b);
    return (a > b) ? a : b;
  endfunction
endpackage

// File: rtl/prom_wait_timer.sv
module prom_wait_timer #(
  parameter int TW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [TW-1:0] load_val,
  output logic          done
);
  logic [TW-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (load)
      cnt_d = load_val;
    else if (cnt_q != '0)
      cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign done = (cnt_q == '0);

  AST_TMR_RELOAD_AT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    load |-> (cnt_q == '0)); // R2
endmodule

// File: rtl/prom_page_track.sv
module prom_page_track #(
  parameter int ADDR_W = 21
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            issue,
  input  logic            clear,
  input  logic [ADDR_W:0] cand_addr,
  input  logic            cand_byte,
  output logic            hit,
  output logic            open_vld
);
  localparam int PW = ADDR_W - 3;

  logic [PW-1:0] cand_page, page_q, page_d;
  logic          byte_q, byte_d, vld_q, vld_d;

  assign cand_page = cand_byte ? cand_addr[ADDR_W:4] : cand_addr[ADDR_W-1:3];

  always_comb begin
    page_d = page_q;
    byte_d = byte_q;
    vld_d  = vld_q;
    if (issue) begin
      page_d = cand_page;
      byte_d = cand_byte;
      vld_d  = 1'b1;
    end else if (clear) begin
      vld_d  = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      page_q <= '0;
      byte_q <= 1'b0;
      vld_q  <= 1'b0;
    end else begin
      page_q <= page_d;
      byte_q <= byte_d;
      vld_q  <= vld_d;
    end
  end

  assign hit      = vld_q && (page_q == cand_page) && (byte_q == cand_byte);
  assign open_vld = vld_q;
endmodule

// File: rtl/prom_pin_map.sv
module prom_pin_map #(
  parameter int ADDR_W = 21
) (
  input  logic              elem_addr_0,
  input  logic [ADDR_W:1]   elem_addr_hi,
  input  logic              byte_mode,
  output logic [ADDR_W-1:0] rom_addr,
  output logic              rom_wide,
  output logic              rom_lsb,
  output logic              rom_lsb_drive
);
  always_comb begin
    if (byte_mode) begin
      rom_addr      = elem_addr_hi;
      rom_lsb       = elem_addr_0;
      rom_lsb_drive = 1'b1;
      rom_wide      = 1'b0;
    end else begin
      rom_addr      = {elem_addr_hi[ADDR_W-1:1], elem_addr_0};
      rom_lsb       = 1'b0;
      rom_lsb_drive = 1'b0;
      rom_wide      = 1'b1;
    end
  end
endmodule

// File: rtl/prom_page_reader.sv
module prom_page_reader
  import prom_pkg::*;
#(
  parameter int ADDR_W    = 21,
  parameter int LEN_W     = 5,
  parameter int DATA_W    = 16,
  parameter int CLK_NS    = 8,
  parameter int ACC_NS    = 120,
  parameter int PAGE_NS   = 50,
  parameter int OE_NS     = 50,
  parameter int IDLE_HOLD = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ADDR_W:0]   req_addr,
  input  logic [LEN_W-1:0]  req_len,
  input  logic              req_byte,
  output logic              rd_valid,
  output logic [DATA_W-1:0] rd_data,
  output logic              rom_ce_n,
  output logic              rom_oe_n,
  output logic [ADDR_W-1:0] rom_addr,
  output logic              rom_wide,
  output logic              rom_lsb,
  output logic              rom_lsb_drive,
  input  logic [DATA_W-1:0] rom_data_in
);
  localparam int FULL_I   = cdiv(imax(ACC_NS, OE_NS), CLK_NS);
  localparam int PAGE_I   = cdiv(PAGE_NS, CLK_NS);
  localparam int TW       = $clog2(FULL_I + 1);
  localparam int HW       = $clog2(IDLE_HOLD + 1);
  localparam int HALF_W   = DATA_W / 2;
  localparam logic [TW-1:0] FULL_CYC = TW'(FULL_I);
  localparam logic [TW-1:0] PAGE_CYC = TW'(PAGE_I);
  localparam logic [HW-1:0] HOLD_CYC = HW'(IDLE_HOLD);

  // reset: asynchronous assert, synchronous release
  logic [1:0] rsync_q;
  logic       rst_s_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsync_q <= 2'b00;
    else        rsync_q <= {rsync_q[0], 1'b1};
  end
  assign rst_s_n = rsync_q[1];

  prom_state_e       state_q, state_d;
  logic [ADDR_W:0]   cur_q, cur_d, cur_inc;
  logic [LEN_W-1:0]  left_q, left_d;
  logic              byte_q, byte_d;
  logic              ce_q, ce_d, oe_q, oe_d;
  logic [HW-1:0]     hold_q, hold_d;
  logic              vld_q, vld_d;
  logic [DATA_W-1:0] data_q, data_d;

  logic              issue, clear, page_hit, open_vld, tmr_done;
  logic [ADDR_W:0]   cand_addr;
  logic              cand_byte;
  logic [TW-1:0]     load_val;

  assign cur_inc = cur_q + 1'b1;

  always_comb begin
    state_d   = state_q;
    cur_d     = cur_q;
    left_d    = left_q;
    byte_d    = byte_q;
    ce_d      = ce_q;
    oe_d      = oe_q;
    hold_d    = hold_q;
    vld_d     = 1'b0;
    data_d    = data_q;
    issue     = 1'b0;
    clear     = 1'b0;
    cand_addr = req_addr;
    cand_byte = req_byte;
    unique case (state_q)
      S_IDLE: begin
        if (req_valid) begin
          issue   = 1'b1;
          state_d = S_WAIT;
          cur_d   = req_addr;
          left_d  = req_len;
          byte_d  = req_byte;
          ce_d    = 1'b0;
          oe_d    = 1'b0;
        end else if (!ce_q) begin
          if (hold_q == '0) begin
            ce_d  = 1'b1;
            oe_d  = 1'b1;
            clear = 1'b1;
          end else begin
            hold_d = hold_q - 1'b1;
          end
        end
      end
      S_WAIT: begin
        cand_addr = cur_inc;
        cand_byte = byte_q;
        if (tmr_done) begin
          vld_d  = 1'b1;
          data_d = byte_q ? {{HALF_W{1'b0}}, rom_data_in[HALF_W-1:0]} : rom_data_in;
          if (left_q == '0) begin
            state_d = S_IDLE;
            hold_d  = HOLD_CYC;
          end else begin
            issue  = 1'b1;
            cur_d  = cur_inc;
            left_d = left_q - 1'b1;
          end
        end
      end
      default: state_d = S_IDLE;
    endcase
    load_val = page_hit ? PAGE_CYC : FULL_CYC;
  end

  always_ff @(posedge clk or negedge rst_s_n) begin
    if (!rst_s_n) begin
      state_q <= S_IDLE;
      cur_q   <= '0;
      left_q  <= '0;
      byte_q  <= 1'b0;
      ce_q    <= 1'b1;
      oe_q    <= 1'b1;
      hold_q  <= '0;
      vld_q   <= 1'b0;
      data_q  <= '0;
    end else begin
      state_q <= state_d;
      cur_q   <= cur_d;
      left_q  <= left_d;
      byte_q  <= byte_d;
      ce_q    <= ce_d;
      oe_q    <= oe_d;
      hold_q  <= hold_d;
      vld_q   <= vld_d;
      data_q  <= data_d;
    end
  end

  prom_wait_timer #(.TW(TW)) u_timer (
    .clk(clk), .rst_n(rst_s_n), .load(issue), .load_val(load_val), .done(tmr_done)
  );

  prom_page_track #(.ADDR_W(ADDR_W)) u_track (
    .clk(clk), .rst_n(rst_s_n), .issue(issue), .clear(clear),
    .cand_addr(cand_addr), .cand_byte(cand_byte), .hit(page_hit), .open_vld(open_vld)
  );

  prom_pin_map #(.ADDR_W(ADDR_W)) u_pins (
    .elem_addr_0(cur_q[0]), .elem_addr_hi(cur_q[ADDR_W:1]), .byte_mode(byte_q),
    .rom_addr(rom_addr), .rom_wide(rom_wide), .rom_lsb(rom_lsb), .rom_lsb_drive(rom_lsb_drive)
  );

  assign req_ready = (state_q == S_IDLE);
  assign rd_valid  = vld_q;
  assign rd_data   = data_q;
  assign rom_ce_n  = ce_q;
  assign rom_oe_n  = oe_q;

  AST_ENABLES_IN_BURST: assert property (@(posedge clk) disable iff (!rst_s_n)
    (state_q == S_WAIT) |-> (!rom_ce_n && !rom_oe_n)); // R8
  AST_ADDR_HELD_WAIT: assert property (@(posedge clk) disable iff (!rst_s_n)
    (state_q == S_WAIT && !tmr_done) |=> ($stable(rom_addr) && $stable(rom_lsb))); // R3
  AST_BEATS_SPACED: assert property (@(posedge clk) disable iff (!rst_s_n)
    rd_valid |=> !rd_valid); // R3
  AST_OPEN_PAGE_NEEDS_CE: assert property (@(posedge clk) disable iff (!rst_s_n)
    open_vld |-> !rom_ce_n); // R9
  AST_NO_ACCEPT_BUSY: assert property (@(posedge clk) disable iff (!rst_s_n)
    (!req_ready && !rd_valid) |=> $stable(rom_wide)); // R10
endmodule

// File: tb/tb_prom_page_reader.sv
module tb_prom_page_reader;
  localparam int AW   = 21;
  localparam int LW   = 5;
  localparam int FULL = 15;
  localparam int PAGE = 7;

  logic          clk, rst_n;
  logic          req_valid, req_ready, req_byte;
  logic [AW:0]   req_addr;
  logic [LW-1:0] req_len;
  logic          rd_valid;
  logic [15:0]   rd_data, rom_data_in;
  logic          rom_ce_n, rom_oe_n, rom_wide, rom_lsb, rom_lsb_drive;
  logic [AW-1:0] rom_addr;

  int total = 0, bad = 0, cyc = 0;
  bit finished = 0;

  initial clk = 1'b0;
  always #4 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  function automatic logic [15:0] wv(input logic [AW-1:0] w);
    return w[15:0] ^ 16'hC35A ^ {11'd0, w[20:16]};
  endfunction

  function automatic logic [7:0] bv(input logic [AW:0] b);
    logic [15:0] w;
    w = wv(b[AW:1]);
    return b[0] ? w[15:8] : w[7:0];
  endfunction

  function automatic logic [AW:0] pg(input logic [AW:0] a, input bit byt);
    return byt ? (a >> 4) : ((a & {1'b0, {AW{1'b1}}}) >> 3);
  endfunction

  assign rom_data_in = (rom_ce_n || rom_oe_n) ? 16'hFFFF :
                       rom_wide ? wv(rom_addr) : {8'h7F, bv({rom_addr, rom_lsb})};

  prom_page_reader dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .req_len(req_len), .req_byte(req_byte),
    .rd_valid(rd_valid), .rd_data(rd_data), .rom_ce_n(rom_ce_n), .rom_oe_n(rom_oe_n),
    .rom_addr(rom_addr), .rom_wide(rom_wide), .rom_lsb(rom_lsb),
    .rom_lsb_drive(rom_lsb_drive), .rom_data_in(rom_data_in)
  );

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  task automatic run_burst(input logic [AW:0] a, input int len, input bit byt,
                           input bit first_full, input bit junk, input string tag);
    int t_prev, dl, explat;
    logic [AW:0] cur, nxt;
    logic [15:0] exp;
    while (!req_ready) @(negedge clk);
    req_addr = a; req_len = LW'(len); req_byte = byt; req_valid = 1'b1;
    @(negedge clk);
    t_prev = cyc;
    if (junk) begin req_addr = ~a; req_byte = !byt; req_len = '1; end
    else req_valid = 1'b0;
    check(!rom_ce_n && !rom_oe_n, "R8 enables low", {rom_ce_n, rom_oe_n}, 0);
    if (byt) begin
      check(!rom_wide && rom_lsb_drive, "R6 byte pins", {rom_wide, rom_lsb_drive}, 1);
      check(rom_addr == a[AW:1] && rom_lsb == a[0], "R6 byte address",
            {rom_addr, rom_lsb}, a);
    end else begin
      check(rom_wide && !rom_lsb_drive, "R5 word pins", {rom_wide, rom_lsb_drive}, 2);
      check(rom_addr == a[AW-1:0], "R5 word address", rom_addr, a[AW-1:0]);
    end
    cur = a;
    explat = first_full ? FULL + 1 : PAGE + 1;
    for (int i = 0; i <= len; i++) begin
      @(negedge clk);
      while (!rd_valid) @(negedge clk);
      if (i == len) req_valid = 1'b0;
      dl = cyc - t_prev;
      check(dl == explat, (i == 0) ? tag : ((explat == FULL + 1) ? "R4 boundary latency" : "R3 page latency"),
            dl, explat);
      exp = byt ? {8'h00, bv(cur)} : wv(cur[AW-1:0]);
      check(rd_data == exp, byt ? "R6 byte data" : "R5 word data", rd_data, exp);
      check(req_ready == (i == len), "R7 ready only at last beat", req_ready, i == len);
      t_prev = cyc;
      nxt = cur + 1'b1;
      explat = (pg(nxt, byt) != pg(cur, byt)) ? FULL + 1 : PAGE + 1;
      cur = nxt;
    end
  endtask

  task automatic t_reset();
    rst_n = 1'b0; req_valid = 1'b0; req_addr = '0; req_len = '0; req_byte = 1'b0;
    repeat (3) @(negedge clk);
    check(rom_ce_n && rom_oe_n && !rd_valid, "R1 reset outputs", {rom_ce_n, rom_oe_n, rd_valid}, 6);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check(req_ready && rom_ce_n && rom_oe_n && !rd_valid, "R1 after reset",
          {req_ready, rom_ce_n, rom_oe_n, rd_valid}, 14);
  endtask

  task automatic t_idle_release();
    repeat (30) @(negedge clk);
    check(rom_ce_n && rom_oe_n, "R8 enables released after hold", {rom_ce_n, rom_oe_n}, 3);
    run_burst(22'h000410, 0, 1'b1, 1'b1, 1'b0, "R9 full after release");
  endtask

  task automatic t_busy_ignore();
    repeat (20) @(negedge clk);
    run_burst(22'h002000, 5, 1'b0, 1'b1, 1'b1, "R2 first beat");
    @(negedge clk);
    check(req_ready && !rd_valid, "R10 busy request ignored", {req_ready, rd_valid}, 2);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    summary();
  end

  initial begin
    t_reset();
    run_burst(22'h000100, 3, 1'b0, 1'b1, 1'b0, "R2 first beat");
    run_burst(22'h000104, 1, 1'b0, 1'b0, 1'b0, "R9 reuse open page");
    run_burst(22'h0001F6, 3, 1'b0, 1'b1, 1'b0, "R4 new page start");
    run_burst(22'h00040E, 3, 1'b1, 1'b1, 1'b0, "R9 full after width change");
    t_idle_release();
    t_busy_ignore();
    summary();
  end
endmodule